// File: doc/BRIEF.md
# Scoreboard Issue and Hazard Controller

This block is the control core of a single-issue processor that overlaps the execution of several instructions. Each cycle it is offered at most one decoded instruction: an operation class, a destination register, two source registers and a flag saying whether the instruction writes a register at all. It answers with a combinational ready. Accepted instructions are placed into one of several replicated functional units. Each unit keeps a status entry with its destination, its two sources, the units producing those sources and a ready flag per source. A per-register table records which unit, if any, will write each register.

Every instruction passes through issue, operand read, a timed execution phase and write-back, in that order. The execution phase is modelled by a countdown timer per unit; there is no datapath. Operand reads and write-backs are reported on strobe outputs so a register file, or a bench, can follow them. Write-backs always happen in program order.

A configuration input selects where the source-flag refresh after a write-back happens. It can take place in the write-back cycle itself, or in a separate step one cycle later. Instructions without a destination, such as stores or branches, flow through the units like any other operation. They never claim a register entry and never redirect anything.

Top module: `scoreboard_ctrl`

## Requirements
- R1: `in_op` codes classes as 0 load/store, 1 integer, 2 float multiply, 3 float divide, 4 float add/subtract; codes 5 to 7 never raise `in_ready`, and with no stall condition a valid code raises it in the same cycle.
- R2: The default build has two load/store, two integer, two multiply, one divide and one add/subtract unit. `in_ready` is low while every unit of the requested class is busy, and a unit freed by a write-back in cycle t can accept an instruction in cycle t+1.
- R3: An instruction with a destination stalls while that register has a pending writer, and issues no earlier than the cycle after that writer's write-back.
- R4: With `in_nodst`=1 the instruction claims no register entry, causes no destination stall, and its write-back reports `wb_has_dst`=0.
- R5: A unit reads its operands only once both source flags are ready, at most one read per cycle (lowest unit index first); an instruction with no pending sources reads in the cycle after it issues.
- R6: Execution lasts the class latency (load/store 2 plus 1 extra memory cycle, integer 1, multiply 4, divide 6, add/subtract 2), so a write-back comes no earlier than read cycle + latency + 1, and exactly then when nothing blocks it.
- R7: Write-backs occur in issue order, one per cycle at most; a finished younger instruction waits for all older ones.
- R8: A write-back of register d is held while another busy unit still has d as a ready but unread source.
- R9: With `cfg_flag_merge`=1 a dependent instruction reads its operands in the cycle after its producer's write-back.
- R10: With `cfg_flag_merge`=0 the source flags are refreshed one cycle after the write-back, so the dependent reads two cycles after it.
- R11: After reset no unit is busy, `rd_valid` and `wb_valid` are low, and any valid class is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_flag_merge | input | 1 | 1: refresh source flags in the write-back cycle; 0: in a separate step a cycle later |
| in_valid | input | 1 | Decoded instruction offered |
| in_op | input | 3 | Operation class code |
| in_nodst | input | 1 | Instruction writes no register |
| in_dst | input | log2(NREG) | Destination register |
| in_src1 | input | log2(NREG) | First source register |
| in_src2 | input | log2(NREG) | Second source register |
| in_ready | output | 1 | Instruction accepted this cycle when valid |
| rd_valid | output | 1 | Operand read strobe |
| rd_unit | output | log2(units) | Unit reading its operands |
| rd_src1 | output | log2(NREG) | First register read |
| rd_src2 | output | log2(NREG) | Second register read |
| wb_valid | output | 1 | Write-back strobe |
| wb_unit | output | log2(units) | Unit writing back |
| wb_reg | output | log2(NREG) | Register written |
| wb_has_dst | output | 1 | The write-back targets a register |

## Verification
Two pairs of functions can land in one cycle. The first pair is a producer's write-back and the refresh of a dependent's source flag. The bench issues a multiply followed by an integer operation that reads its result, once in each setting of `cfg_flag_merge`, and checks that the operand read follows the write-back by exactly one or two cycles. The second pair is the write-back of one unit and the operand read of an older unit that still needs the old value of the same register. The bench builds that chain behind a long divide and checks that the younger write-back lands strictly after the older read. Per-class latency sweeps and structural, destination and ordering stalls are judged against cycle counts the bench works out from the latency table.

// File: rtl/sb_pkg.sv
package sb_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam logic [2:0] CLS_MEM  = 3'd0;
  localparam logic [2:0] CLS_INT  = 3'd1;
  localparam logic [2:0] CLS_FMUL = 3'd2;
  localparam logic [2:0] CLS_FDIV = 3'd3;
  localparam logic [2:0] CLS_FADD = 3'd4;

  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_EXEC, PH_DONE} phase_e;

  // Units are laid out class by class in code order.
  function automatic logic [2:0] class_of_unit(input int i, input int n_mem,
      input int n_int, input int n_fmul, input int n_fdiv);
    if (i < n_mem) return CLS_MEM;
    if (i < n_mem + n_int) return CLS_INT;
    if (i < n_mem + n_int + n_fmul) return CLS_FMUL;
    if (i < n_mem + n_int + n_fmul + n_fdiv) return CLS_FDIV;
    return CLS_FADD;
  endfunction

  function automatic int exec_cycles(input logic [2:0] cls, input int l_mem,
      input int l_int, input int l_fmul, input int l_fdiv, input int l_fadd,
      input int mem_extra);
    case (cls)
      CLS_MEM:  return l_mem + mem_extra;
      CLS_INT:  return l_int;
      CLS_FMUL: return l_fmul;
      CLS_FDIV: return l_fdiv;
      default:  return l_fadd;
    endcase
  endfunction
endpackage

// File: rtl/sb_first_pick.sv
module sb_first_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  timeunit 1ns; timeprecision 1ps;
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/sb_exec_timer.sv
module sb_exec_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] load,
  output logic          finish
);
  timeunit 1ns; timeprecision 1ps;
  logic [TW-1:0] cnt_q;
  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (start)           cnt_q <= load;
    else if (cnt_q != '0)     cnt_q <= cnt_q - TW'(1);
  end
  assign finish = (cnt_q == TW'(1));
endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl import sb_pkg::*; #(
  parameter int NREG      = 32,
  parameter int N_MEM     = 2,
  parameter int N_INT     = 2,
  parameter int N_FMUL    = 2,
  parameter int N_FDIV    = 1,
  parameter int N_FADD    = 1,
  parameter int LAT_MEM   = 2,
  parameter int LAT_INT   = 1,
  parameter int LAT_FMUL  = 4,
  parameter int LAT_FDIV  = 6,
  parameter int LAT_FADD  = 2,
  parameter int MEM_EXTRA = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_flag_merge,
  input  logic in_valid,
  input  logic [2:0] in_op,
  input  logic in_nodst,
  input  logic [$clog2(NREG)-1:0] in_dst,
  input  logic [$clog2(NREG)-1:0] in_src1,
  input  logic [$clog2(NREG)-1:0] in_src2,
  output logic in_ready,
  output logic rd_valid,
  output logic [$clog2(N_MEM+N_INT+N_FMUL+N_FDIV+N_FADD)-1:0] rd_unit,
  output logic [$clog2(NREG)-1:0] rd_src1,
  output logic [$clog2(NREG)-1:0] rd_src2,
  output logic wb_valid,
  output logic [$clog2(N_MEM+N_INT+N_FMUL+N_FDIV+N_FADD)-1:0] wb_unit,
  output logic [$clog2(NREG)-1:0] wb_reg,
  output logic wb_has_dst
);
  timeunit 1ns; timeprecision 1ps;

  localparam int NFU = N_MEM + N_INT + N_FMUL + N_FDIV + N_FADD;
  localparam int UW  = $clog2(NFU);
  localparam int RW  = $clog2(NREG);
  localparam int QW  = $clog2(NFU + 1);
  localparam int SW  = UW + 1;
  localparam int TW  = $clog2(LAT_MEM + MEM_EXTRA + LAT_INT + LAT_FMUL + LAT_FDIV + LAT_FADD + 1);

  // Unit status
  logic [NFU-1:0] busy_q, rj_q, rk_q, nodst_q;
  phase_e         ph_q  [NFU];
  logic [RW-1:0]  fi_q  [NFU];
  logic [RW-1:0]  fj_q  [NFU];
  logic [RW-1:0]  fk_q  [NFU];
  logic [QW-1:0]  qj_q  [NFU];
  logic [QW-1:0]  qk_q  [NFU];
  logic [SW-1:0]  seq_q [NFU];
  // Register result status: 0 = no writer, else unit index + 1
  logic [QW-1:0]  regstat_q [NREG];
  logic [SW-1:0]  iss_seq_q, ret_seq_q;
  logic           upd_pend_q;
  logic [QW-1:0]  upd_tag_q;

  // Named events
  logic [NFU-1:0] iss_req, rd_req, wb_req, war_blk, tmr_fin;
  logic           iss_found, issue_fire, rd_fire, wb_fire, waw_hit, cls_ok;
  logic [UW-1:0]  iss_idx, rd_idx, wb_idx;
  logic           flag_clr_en;
  logic [QW-1:0]  flag_clr_tag, wb_tag, src1_tag, src2_tag;

  function automatic logic [QW-1:0] unit_tag(input logic [UW-1:0] u);
    return QW'(u) + QW'(1);
  endfunction

  for (genvar g = 0; g < NFU; g++) begin : g_unit
    localparam logic [2:0] UCLS = class_of_unit(g, N_MEM, N_INT, N_FMUL, N_FDIV);
    assign iss_req[g] = !busy_q[g] && (UCLS == in_op);
    assign rd_req[g]  = busy_q[g] && (ph_q[g] == PH_WAIT) && rj_q[g] && rk_q[g];
    assign wb_req[g]  = busy_q[g] && (ph_q[g] == PH_DONE) &&
                        (seq_q[g] == ret_seq_q) && !war_blk[g];
    sb_exec_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n),
      .start(rd_fire && (rd_idx == UW'(g))),
      .load(TW'(exec_cycles(UCLS, LAT_MEM, LAT_INT, LAT_FMUL, LAT_FDIV, LAT_FADD, MEM_EXTRA))),
      .finish(tmr_fin[g]));
  end

  // WAR: hold a write while an older reader still needs the old value
  always_comb begin
    for (int i = 0; i < NFU; i++) begin
      war_blk[i] = 1'b0;
      for (int j = 0; j < NFU; j++) begin
        if (j != i && busy_q[j] &&
            ((fj_q[j] == fi_q[i] && rj_q[j]) || (fk_q[j] == fi_q[i] && rk_q[j])))
          war_blk[i] = 1'b1;
      end
      if (nodst_q[i]) war_blk[i] = 1'b0;
    end
  end

  sb_first_pick #(.N(NFU), .IW(UW)) u_pick_iss (.req(iss_req), .found(iss_found), .idx(iss_idx));
  sb_first_pick #(.N(NFU), .IW(UW)) u_pick_rd  (.req(rd_req),  .found(rd_fire),   .idx(rd_idx));
  sb_first_pick #(.N(NFU), .IW(UW)) u_pick_wb  (.req(wb_req),  .found(wb_fire),   .idx(wb_idx));

  assign cls_ok     = (in_op <= CLS_FADD);
  assign waw_hit    = !in_nodst && (regstat_q[in_dst] != '0);
  assign in_ready   = cls_ok && iss_found && !waw_hit;
  assign issue_fire = in_valid && in_ready;
  assign wb_tag     = unit_tag(wb_idx);

  assign flag_clr_en  = cfg_flag_merge ? wb_fire : upd_pend_q;
  assign flag_clr_tag = cfg_flag_merge ? wb_tag  : upd_tag_q;

  // A source whose producer writes back this very cycle is ready when merged
  always_comb begin
    src1_tag = regstat_q[in_src1];
    src2_tag = regstat_q[in_src2];
    if (cfg_flag_merge && wb_fire && src1_tag == wb_tag) src1_tag = '0;
    if (cfg_flag_merge && wb_fire && src2_tag == wb_tag) src2_tag = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0; rj_q <= '0; rk_q <= '0; nodst_q <= '0;
      for (int i = 0; i < NFU; i++) begin
        ph_q[i] <= PH_IDLE; fi_q[i] <= '0; fj_q[i] <= '0; fk_q[i] <= '0;
        qj_q[i] <= '0; qk_q[i] <= '0; seq_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NFU; i++) begin
        if (issue_fire && iss_idx == UW'(i)) begin
          busy_q[i] <= 1'b1;  ph_q[i] <= PH_WAIT;  nodst_q[i] <= in_nodst;
          fi_q[i] <= in_dst;  fj_q[i] <= in_src1;  fk_q[i] <= in_src2;
          qj_q[i] <= src1_tag; qk_q[i] <= src2_tag;
          rj_q[i] <= (src1_tag == '0); rk_q[i] <= (src2_tag == '0);
          seq_q[i] <= iss_seq_q;
        end else begin
          if (flag_clr_en && qj_q[i] == flag_clr_tag) begin qj_q[i] <= '0; rj_q[i] <= 1'b1; end
          if (flag_clr_en && qk_q[i] == flag_clr_tag) begin qk_q[i] <= '0; rk_q[i] <= 1'b1; end
          if (rd_fire && rd_idx == UW'(i)) begin
            rj_q[i] <= 1'b0; rk_q[i] <= 1'b0; ph_q[i] <= PH_EXEC;
          end
          if (tmr_fin[i] && ph_q[i] == PH_EXEC) ph_q[i] <= PH_DONE;
          if (wb_fire && wb_idx == UW'(i)) begin
            busy_q[i] <= 1'b0; ph_q[i] <= PH_IDLE;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) regstat_q[r] <= '0;
      iss_seq_q <= '0; ret_seq_q <= '0; upd_pend_q <= 1'b0; upd_tag_q <= '0;
    end else begin
      if (wb_fire && !nodst_q[wb_idx]) regstat_q[fi_q[wb_idx]] <= '0;
      if (issue_fire && !in_nodst) regstat_q[in_dst] <= unit_tag(iss_idx);
      if (issue_fire) iss_seq_q <= iss_seq_q + SW'(1);
      if (wb_fire)    ret_seq_q <= ret_seq_q + SW'(1);
      upd_pend_q <= wb_fire && !cfg_flag_merge;
      upd_tag_q  <= wb_tag;
    end
  end

  assign rd_valid   = rd_fire;
  assign rd_unit    = rd_idx;
  assign rd_src1    = fj_q[rd_idx];
  assign rd_src2    = fk_q[rd_idx];
  assign wb_valid   = wb_fire;
  assign wb_unit    = wb_idx;
  assign wb_reg     = fi_q[wb_idx];
  assign wb_has_dst = !nodst_q[wb_idx];
endmodule

// File: rtl/sb_checker.sv
module sb_checker import sb_pkg::*; #(
  parameter int NREG = 32, parameter int N_MEM = 2, parameter int N_INT = 2,
  parameter int N_FMUL = 2, parameter int N_FDIV = 1, parameter int N_FADD = 1,
  parameter int LAT_MEM = 2, parameter int LAT_INT = 1, parameter int LAT_FMUL = 4,
  parameter int LAT_FDIV = 6, parameter int LAT_FADD = 2, parameter int MEM_EXTRA = 1
) (
  input logic clk,
  input logic rst_n,
  input logic [2:0] in_op,
  input logic in_valid,
  input logic in_ready,
  input logic in_nodst,
  input logic [$clog2(NREG)-1:0] in_dst,
  input logic [$clog2(N_MEM+N_INT+N_FMUL+N_FDIV+N_FADD)-1:0] iss_idx,
  input logic rd_valid,
  input logic [$clog2(N_MEM+N_INT+N_FMUL+N_FDIV+N_FADD)-1:0] rd_unit,
  input logic wb_valid,
  input logic [$clog2(N_MEM+N_INT+N_FMUL+N_FDIV+N_FADD)-1:0] wb_unit,
  input logic [$clog2(NREG)-1:0] wb_reg,
  input logic wb_has_dst
);
  timeunit 1ns; timeprecision 1ps;
  localparam int NFU = N_MEM + N_INT + N_FMUL + N_FDIV + N_FADD;

  logic [NFU-1:0]  c_busy, c_read;
  logic [7:0]      c_since [NFU];
  logic [NREG-1:0] c_pend;
  logic            acc;
  int              min_wb [NFU];

  assign acc = in_valid && in_ready;
  always_comb
    for (int i = 0; i < NFU; i++)
      min_wb[i] = exec_cycles(class_of_unit(i, N_MEM, N_INT, N_FMUL, N_FDIV),
                              LAT_MEM, LAT_INT, LAT_FMUL, LAT_FDIV, LAT_FADD, MEM_EXTRA) + 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_busy <= '0; c_read <= '0; c_pend <= '0;
      for (int i = 0; i < NFU; i++) c_since[i] <= '0;
    end else begin
      for (int i = 0; i < NFU; i++)
        if (c_since[i] != 8'hFF) c_since[i] <= c_since[i] + 8'd1;
      if (rd_valid) begin c_read[rd_unit] <= 1'b1; c_since[rd_unit] <= 8'd1; end
      if (wb_valid) c_busy[wb_unit] <= 1'b0;
      if (wb_valid && wb_has_dst) c_pend[wb_reg] <= 1'b0;
      if (acc) begin c_busy[iss_idx] <= 1'b1; c_read[iss_idx] <= 1'b0; end
      if (acc && !in_nodst) c_pend[in_dst] <= 1'b1;
    end
  end

  assert_bad_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_op > 3'd4) |-> !in_ready);
  assert_no_waw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_nodst) |-> !c_pend[in_dst]);
  assert_read_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (c_busy[rd_unit] && !c_read[rd_unit]));
  assert_min_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (c_read[wb_unit] && int'(c_since[wb_unit]) >= min_wb[wb_unit]));
  assert_wb_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> c_busy[wb_unit]);
endmodule

bind scoreboard_ctrl sb_checker #(
  .NREG(NREG), .N_MEM(N_MEM), .N_INT(N_INT), .N_FMUL(N_FMUL), .N_FDIV(N_FDIV),
  .N_FADD(N_FADD), .LAT_MEM(LAT_MEM), .LAT_INT(LAT_INT), .LAT_FMUL(LAT_FMUL),
  .LAT_FDIV(LAT_FDIV), .LAT_FADD(LAT_FADD), .MEM_EXTRA(MEM_EXTRA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_op(in_op), .in_valid(in_valid), .in_ready(in_ready),
  .in_nodst(in_nodst), .in_dst(in_dst), .iss_idx(iss_idx), .rd_valid(rd_valid),
  .rd_unit(rd_unit), .wb_valid(wb_valid), .wb_unit(wb_unit), .wb_reg(wb_reg),
  .wb_has_dst(wb_has_dst)
);

// File: tb/sim_scoreboard_ctrl.sv
module sim_scoreboard_ctrl;
  timeunit 1ns; timeprecision 1ps;

  logic clk = 1'b0, rst_n = 1'b0, cfg_flag_merge = 1'b1;
  logic in_valid = 1'b0, in_nodst = 1'b0;
  logic [2:0] in_op = 3'd1, in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic in_ready, rd_valid, wb_valid, wb_has_dst;
  logic [2:0] rd_unit, wb_unit, rd_src1, rd_src2, wb_reg;

  scoreboard_ctrl #(.NREG(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_flag_merge(cfg_flag_merge), .in_valid(in_valid),
    .in_op(in_op), .in_nodst(in_nodst), .in_dst(in_dst), .in_src1(in_src1),
    .in_src2(in_src2), .in_ready(in_ready), .rd_valid(rd_valid), .rd_unit(rd_unit),
    .rd_src1(rd_src1), .rd_src2(rd_src2), .wb_valid(wb_valid), .wb_unit(wb_unit),
    .wb_reg(wb_reg), .wb_has_dst(wb_has_dst));

  always #2 clk = ~clk;   // 250 MHz

  int cyc = 0, total = 0, bad = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Event logs sampled mid-cycle
  int rd_c [64]; int rd_a [64]; int rd_b [64]; int nrd = 0;
  int wb_c [64]; int wb_r [64]; bit wb_h [64]; int nwb = 0;
  always @(negedge clk) if (rst_n) begin
    if (rd_valid && nrd < 64) begin
      rd_c[nrd] = cyc; rd_a[nrd] = int'(rd_src1); rd_b[nrd] = int'(rd_src2); nrd++;
    end
    if (wb_valid && nwb < 64) begin
      wb_c[nwb] = cyc; wb_r[nwb] = int'(wb_reg); wb_h[nwb] = wb_has_dst; nwb++;
    end
  end

  // Execution cycles per class, restated from the latency table
  function automatic int ex_len(input int c);
    int t [5] = '{3, 1, 4, 6, 2};
    return t[c];
  endfunction

  function automatic int find_rd(input int a, input int b);
    for (int k = 0; k < nrd; k++) if (rd_a[k] == a && rd_b[k] == b) return rd_c[k];
    return -1;
  endfunction
  function automatic int find_wb(input int r, input bit h);
    for (int k = 0; k < nwb; k++) if (wb_h[k] == h && (!h || wb_r[k] == r)) return wb_c[k];
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clear_logs(); nrd = 0; nwb = 0; endtask
  task automatic drain(); repeat (18) @(negedge clk); endtask

  task automatic issue(input int op, input int d, input int s1, input int s2,
                       input bit nd, output int t, output bit first_rdy);
    in_op = 3'(op); in_dst = 3'(d); in_src1 = 3'(s1); in_src2 = 3'(s2);
    in_nodst = nd; in_valid = 1'b1;
    #1; first_rdy = in_ready;
    while (!in_ready) begin @(negedge clk); #1; end
    t = cyc;
    @(negedge clk); in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t1, t2, t3, w1, w2, r1;
    bit fr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    in_op = 3'd1; #1;
    chk(in_ready == 1'b1, "R11 ready after reset", int'(in_ready), 1);
    chk(rd_valid == 1'b0, "R11 no read after reset", int'(rd_valid), 0);
    chk(wb_valid == 1'b0, "R11 no write-back after reset", int'(wb_valid), 0);
    // R1 unused class codes
    in_op = 3'd5; #0.1;
    chk(in_ready == 1'b0, "R1 code 5 refused", int'(in_ready), 0);
    in_op = 3'd7; #0.1;
    chk(in_ready == 1'b0, "R1 code 7 refused", int'(in_ready), 0);
    @(negedge clk);

    // R5/R6 per-class sweep, lone instruction
    for (int c = 0; c < 5; c++) begin
      clear_logs();
      issue(c, 1, 2, 3, 0, t1, fr);
      drain();
      r1 = find_rd(2, 3); w1 = find_wb(1, 1);
      chk(r1 == t1 + 1, "R5 read one cycle after issue", r1 - t1, 1);
      chk(w1 == t1 + 2 + ex_len(c), "R6 class latency", w1 - t1, 2 + ex_len(c));
    end

    // R2 two load/store units accept back to back
    clear_logs();
    issue(0, 1, 2, 3, 0, t1, fr);
    issue(0, 4, 2, 3, 0, t2, fr);
    chk(t2 == t1 + 1, "R2 second memory unit free", t2 - t1, 1);
    drain();

    // R2 single divider: structural stall
    clear_logs();
    issue(3, 1, 2, 3, 0, t1, fr);
    issue(3, 2, 4, 5, 0, t2, fr);
    drain();
    w1 = find_wb(1, 1);
    chk(fr == 1'b0, "R2 divider busy stalls", int'(fr), 0);
    chk(t2 == w1 + 1, "R2 divider reused after write-back", t2 - w1, 1);

    // R3 destination stall
    clear_logs();
    issue(3, 3, 4, 5, 0, t1, fr);
    issue(1, 3, 6, 7, 0, t2, fr);
    drain();
    w1 = find_wb(3, 1);
    chk(fr == 1'b0, "R3 pending writer stalls", int'(fr), 0);
    chk(t2 == w1 + 1, "R3 issue after write-back", t2 - w1, 1);

    // R7 in-order write-back
    clear_logs();
    issue(3, 1, 2, 3, 0, t1, fr);
    issue(1, 2, 4, 5, 0, t2, fr);
    drain();
    w1 = find_wb(1, 1); w2 = find_wb(2, 1);
    chk(w2 == w1 + 1, "R7 young waits for old", w2 - w1, 1);
    chk(find_rd(4, 5) == t2 + 1, "R5 independent read not delayed", find_rd(4, 5) - t2, 1);

    // R9 merged flag refresh
    cfg_flag_merge = 1'b1;
    clear_logs();
    issue(2, 1, 2, 3, 0, t1, fr);
    issue(1, 4, 1, 5, 0, t2, fr);
    drain();
    w1 = find_wb(1, 1); r1 = find_rd(1, 5);
    chk(r1 == w1 + 1, "R9 dependent read after write-back", r1 - w1, 1);
    chk(find_wb(4, 1) == r1 + 2, "R6 dependent finishes", find_wb(4, 1) - r1, 2);

    // R10 separate flag refresh step
    cfg_flag_merge = 1'b0;
    clear_logs();
    issue(2, 1, 2, 3, 0, t1, fr);
    issue(1, 4, 1, 5, 0, t2, fr);
    drain();
    w1 = find_wb(1, 1); r1 = find_rd(1, 5);
    chk(r1 == w1 + 2, "R10 dependent read two cycles after", r1 - w1, 2);
    cfg_flag_merge = 1'b1;

    // R8 younger writer of an operand still unread by an older unit
    clear_logs();
    issue(3, 1, 6, 7, 0, t1, fr);
    issue(1, 2, 1, 3, 0, t2, fr);
    issue(1, 3, 4, 5, 0, t3, fr);
    drain();
    r1 = find_rd(1, 3); w2 = find_wb(3, 1);
    chk(r1 > 0 && w2 > r1, "R8 write of r3 after older read", w2 - r1, 1);

    // R4 no-destination instruction
    clear_logs();
    issue(0, 5, 1, 2, 1, t1, fr);
    issue(1, 5, 3, 4, 0, t2, fr);
    drain();
    w1 = find_wb(0, 0); w2 = find_wb(5, 1);
    chk(t2 == t1 + 1, "R4 no destination stall", t2 - t1, 1);
    chk(w1 == t1 + 2 + ex_len(0), "R4 store write-back without register", w1 - t1, 2 + ex_len(0));
    chk(w2 == w1 + 1, "R4 R7 later writer follows store", w2 - w1, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule